// File: doc/BRIEF.md
# Flash Erase-Block Protection Manager

This block holds the write-protection state of every erase block in a 2M-word by 16-bit flash array. The array has two block sizes. The lower part is split into large 32K-word main blocks. The topmost 32K words are split into eight 4K-word parameter blocks. In total there are 71 blocks. A command parser upstream issues single-cycle strobes to lock, unlock or lock down the block that holds a given word address. The new state takes effect on the next clock edge, with no busy period.

Two ports serve the program/erase controller and the status path. The first is a combinational query that says whether a program or erase to a given address may go ahead. This answer combines the block's own state with a write-protect pin and a supply-lockout input. The second is a registered status port that returns the 2-bit state of any block.

Top module: `flash_lock_mgr`

## Requirements
- R1: While `rst` is high on a clock edge, every block returns to state 01 (locked), and `status_state` reads 01. After reset, every block reports `query_ok` = 0.
- R2: Let hi = addr[20:15]. When hi is below 63, the block index is hi. When hi equals 63, the index is 63 + addr[14:12]. A command affects only the block at that index.
- R3: A lock strobe sets the lock bit (bit 0) of the addressed block at the next edge. An unlock strobe clears that bit at the next edge, so an unlocked block reads 00 and a locked one reads 01.
- R4: A lock-down strobe sets both bits (state 11). When several strobes arrive in one cycle, lock-down wins over lock, and lock wins over unlock.
- R5: When `prot_n` is low, an unlock strobe has no effect on a block whose lock-down flag (bit 1) is set.
- R6: When `prot_n` is high, unlock and lock strobes change bit 0 of a locked-down block (giving 10 or 11). Bit 1 stays set and only a reset clears it.
- R7: `query_ok` is combinational. It is 1 only when the addressed block has bit 0 clear and is not (bit 1 set with `prot_n` low).
- R8: When `supply_lockout` is high, `query_ok` is 0 for every address.
- R9: `status_state` shows, one clock after each edge, the state that the block addressed by `status_addr` held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_lock | input | 1 | Lock strobe |
| cmd_unlock | input | 1 | Unlock strobe |
| cmd_lockdown | input | 1 | Lock-down strobe |
| cmd_addr | input | 21 | Word address that selects the target block |
| prot_n | input | 1 | Write-protect pin, low = protect locked-down blocks |
| supply_lockout | input | 1 | Programming supply below threshold |
| query_addr | input | 21 | Address of the program/erase being checked |
| query_ok | output | 1 | Program/erase allowed at `query_addr` |
| status_addr | input | 21 | Address of the block whose state is read |
| status_state | output | 2 | Registered state of that block |

## Verification
The bench targets the seam between main and parameter blocks. It uses the last main block and the first and last parameter blocks, and it queries at offsets inside a block. A decoder that used the wrong bit field would open or close the neighbouring block. It drives a locked-down block through every `prot_n` combination. A design that cleared the lock-down flag on unlock, or that honoured unlock while protected, would show 00 or a wrong `query_ok`. It also raises several strobes at once to catch a wrong priority. It forces supply lockout on an open block, and it checks that only reset removes lock-down.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_UNLOCK   = 2'b01,
    OP_LOCK     = 2'b10,
    OP_LOCKDOWN = 2'b11
  } flk_op_e;

  localparam logic [1:0] ST_RESET = 2'b01;
endpackage

// File: rtl/flk_addr_decode.sv
module flk_addr_decode #(
  parameter int ADDR_W    = 21,
  parameter int MAIN_LSB  = 15,
  parameter int PARAM_LSB = 12,
  parameter int IDX_W     = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int HI_W  = ADDR_W - MAIN_LSB;
  localparam int SUB_W = MAIN_LSB - PARAM_LSB;
  localparam int TOP_HI = (1 << HI_W) - 1;

  logic [HI_W-1:0]  hi;
  logic [SUB_W-1:0] sub;

  assign hi  = addr[ADDR_W-1:MAIN_LSB];
  assign sub = addr[MAIN_LSB-1:PARAM_LSB];

  // top main-sized region is split into small parameter blocks
  always_comb begin
    if (&hi) idx = IDX_W'(TOP_HI) + IDX_W'(sub);
    else     idx = IDX_W'(hi);
  end
endmodule

// File: rtl/flk_block_cell.sv
module flk_block_cell
  import flk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  flk_op_e    op,
  input  logic       prot_n,
  output logic [1:0] state
);
  logic lk_q, ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q <= ST_RESET[1];
      lk_q <= ST_RESET[0];
    end else if (sel) begin
      case (op)
        OP_LOCKDOWN: begin
          ld_q <= 1'b1;
          lk_q <= 1'b1;
        end
        OP_LOCK:   lk_q <= 1'b1;
        OP_UNLOCK: if (!ld_q || prot_n) lk_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign state = {ld_q, lk_q};

  assert_reset_locked_R1: assert property (@(posedge clk)
    rst |=> (state == 2'b01));

  assert_lock_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (sel && op == OP_LOCK) |=> lk_q);

  assert_protected_stays_R5: assert property (@(posedge clk) disable iff (rst)
    (ld_q && lk_q && !prot_n) |=> lk_q);

  assert_lockdown_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ld_q |=> ld_q);
endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
  import flk_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int MAIN_LSB  = 15,
  parameter int PARAM_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_lock,
  input  logic              cmd_unlock,
  input  logic              cmd_lockdown,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              prot_n,
  input  logic              supply_lockout,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              query_ok,
  input  logic [ADDR_W-1:0] status_addr,
  output logic [1:0]        status_state
);
  localparam int N_MAIN   = (1 << (ADDR_W - MAIN_LSB)) - 1;
  localparam int N_PARAM  = 1 << (MAIN_LSB - PARAM_LSB);
  localparam int N_BLOCKS = N_MAIN + N_PARAM;
  localparam int IDX_W    = $clog2(N_BLOCKS);

  logic [IDX_W-1:0] cmd_idx, q_idx, s_idx;
  flk_op_e          op;
  logic [1:0]       st [N_BLOCKS];
  logic [1:0]       q_st;

  flk_addr_decode #(.ADDR_W(ADDR_W), .MAIN_LSB(MAIN_LSB), .PARAM_LSB(PARAM_LSB), .IDX_W(IDX_W))
    u_dec_cmd (.addr(cmd_addr), .idx(cmd_idx));
  flk_addr_decode #(.ADDR_W(ADDR_W), .MAIN_LSB(MAIN_LSB), .PARAM_LSB(PARAM_LSB), .IDX_W(IDX_W))
    u_dec_qry (.addr(query_addr), .idx(q_idx));
  flk_addr_decode #(.ADDR_W(ADDR_W), .MAIN_LSB(MAIN_LSB), .PARAM_LSB(PARAM_LSB), .IDX_W(IDX_W))
    u_dec_sts (.addr(status_addr), .idx(s_idx));

  // strobe priority: lock-down, then lock, then unlock
  always_comb begin
    if (cmd_lockdown)    op = OP_LOCKDOWN;
    else if (cmd_lock)   op = OP_LOCK;
    else if (cmd_unlock) op = OP_UNLOCK;
    else                 op = OP_NONE;
  end

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_blk
    flk_block_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .sel   (cmd_idx == IDX_W'(b)),
      .op    (op),
      .prot_n(prot_n),
      .state (st[b])
    );
  end

  assign q_st     = st[q_idx];
  assign query_ok = !supply_lockout && !q_st[0] && !(q_st[1] && !prot_n);

  always_ff @(posedge clk) begin
    if (rst) status_state <= ST_RESET;
    else     status_state <= st[s_idx];
  end

  assert_lockout_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    query_ok |-> !supply_lockout);

  assert_reset_status_R1: assert property (@(posedge clk)
    rst |=> (status_state == 2'b01));
endmodule

// File: tb/sim_flash_lock_mgr.sv
module sim_flash_lock_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int N_ROWS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_lock = 1'b0, cmd_unlock = 1'b0, cmd_lockdown = 1'b0;
  logic [20:0] cmd_addr = '0, query_addr = '0, status_addr = '0;
  logic        prot_n = 1'b0, supply_lockout = 1'b0;
  logic        query_ok;
  logic [1:0]  status_state;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_lock_mgr u0 (
    .clk(clk), .rst(rst),
    .cmd_lock(cmd_lock), .cmd_unlock(cmd_unlock), .cmd_lockdown(cmd_lockdown),
    .cmd_addr(cmd_addr), .prot_n(prot_n), .supply_lockout(supply_lockout),
    .query_addr(query_addr), .query_ok(query_ok),
    .status_addr(status_addr), .status_state(status_state)
  );

  // row: op[2] (0 none,1 unlock,2 lock,3 lockdown), idx[7], prot_n[1], exp_state[2], exp_ok[1], req[4]
  localparam logic [16:0] TBL [N_ROWS] = '{
    {2'd1, 7'd0,  1'b1, 2'b00, 1'b1, 4'd3},  // R3 unlock main 0
    {2'd1, 7'd70, 1'b0, 2'b00, 1'b1, 4'd2},  // R2 last parameter block
    {2'd2, 7'd0,  1'b0, 2'b01, 1'b0, 4'd3},  // R3 relock
    {2'd1, 7'd62, 1'b0, 2'b00, 1'b1, 4'd2},  // R2 last main block
    {2'd1, 7'd63, 1'b0, 2'b00, 1'b1, 4'd2},  // R2 first parameter block
    {2'd2, 7'd63, 1'b0, 2'b01, 1'b0, 4'd3},  // R3
    {2'd3, 7'd64, 1'b0, 2'b11, 1'b0, 4'd4},  // R4 lock-down
    {2'd1, 7'd64, 1'b0, 2'b11, 1'b0, 4'd5},  // R5 unlock ignored
    {2'd1, 7'd64, 1'b1, 2'b10, 1'b1, 4'd6},  // R6 unlock under prot_n high
    {2'd2, 7'd64, 1'b1, 2'b11, 1'b0, 4'd6},  // R6 relock keeps flag
    {2'd1, 7'd64, 1'b1, 2'b10, 1'b1, 4'd6},  // R6
    {2'd0, 7'd64, 1'b0, 2'b10, 1'b0, 4'd7},  // R7 pin low protects
    {2'd2, 7'd64, 1'b0, 2'b11, 1'b0, 4'd6},  // R6 lock allowed when protected
    {2'd1, 7'd65, 1'b0, 2'b00, 1'b1, 4'd2},  // R2 neighbour unaffected
    {2'd1, 7'd69, 1'b1, 2'b00, 1'b1, 4'd3},  // R3
    {2'd0, 7'd66, 1'b1, 2'b01, 1'b0, 4'd2}   // R2 untouched parameter block
  };

  function automatic logic [20:0] base_of(int idx);
    if (idx < 63) return 21'(idx) << 15;
    return (21'd63 << 15) | (21'(idx - 63) << 12);
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // apply op at one edge, status visible one edge later
  task automatic apply(logic [1:0] op, logic [20:0] a, logic pn);
    @(negedge clk);
    cmd_unlock = (op == 2'd1); cmd_lock = (op == 2'd2); cmd_lockdown = (op == 2'd3);
    cmd_addr = a; prot_n = pn; query_addr = a; status_addr = a;
    @(negedge clk);
    cmd_unlock = 0; cmd_lock = 0; cmd_lockdown = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state on several blocks
    foreach (TBL[i]) begin end
    for (int b = 0; b < 71; b += 10) begin
      status_addr = base_of(b); query_addr = base_of(b) + 21'd5;
      @(negedge clk); @(negedge clk);
      check($sformatf("R1 blk%0d", b), {1'b0, status_state, query_ok}, {1'b0, 2'b01, 1'b0});
    end

    for (int r = 0; r < N_ROWS; r++) begin
      apply(TBL[r][16:15], base_of(int'(TBL[r][14:8])), TBL[r][7]);
      check($sformatf("R%0d row%0d", TBL[r][3:0], r), {1'b0, status_state, query_ok},
            {1'b0, TBL[r][6:5], TBL[r][4]});
    end

    // R2: offsets inside block 70 and block 62 boundary
    prot_n = 0;
    query_addr = 21'h1FFFFF; #1;
    check("R2 top word", {3'b0, query_ok}, 4'd1);
    query_addr = base_of(70) - 21'd1; #1;   // inside block 69 (unlocked in table)
    check("R2 blk69 end", {3'b0, query_ok}, 4'd1);
    query_addr = base_of(66) + 21'hFFF; #1;
    check("R2 blk66 end", {3'b0, query_ok}, 4'd0);
    query_addr = base_of(63) - 21'd1; #1;    // block 62, unlocked
    check("R2 blk62 end", {3'b0, query_ok}, 4'd1);

    // R8: lockout on unlocked block
    supply_lockout = 1; #1;
    check("R8 lockout", {3'b0, query_ok}, 4'd0);
    supply_lockout = 0; #1;
    check("R8 release", {3'b0, query_ok}, 4'd1);

    // R4: simultaneous strobes on block 10
    @(negedge clk);
    cmd_unlock = 1; cmd_lock = 1; cmd_addr = base_of(10); status_addr = base_of(10);
    @(negedge clk);
    cmd_unlock = 1; cmd_lock = 0; cmd_lockdown = 1;
    @(negedge clk);
    cmd_unlock = 0; cmd_lockdown = 0;
    @(negedge clk);
    check("R4 priority", {2'b0, status_state}, 4'b0011);

    // R9: status lags by one edge
    status_addr = base_of(62);
    @(posedge clk); #1;
    check("R9 lag", {2'b0, status_state}, 4'b0000);

    // R1/R6: reset clears lock-down flag of block 64
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    apply(2'd1, base_of(64), 1'b1);
    check("R6 reset clears flag", {1'b0, status_state, query_ok}, {1'b0, 2'b00, 1'b1});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule